// File: doc/BRIEF.md
# Circular Page Recording Tracker

This block runs the recording side of a circular page buffer in external memory. Sampled antenna data arrives as fixed-size pages. The data path raises a strobe each time a page is complete and supplies that page's timestamp. The tracker answers each accepted page by moving its write pointer to the next page. It also presents the memory word address of the page that comes next. The pointer wraps to page 0 after a page count held in a register input. One record enable governs every antenna input of the device together.

Alongside the pointer the block keeps the status that lets later software map a time range onto page indices. It holds the index and timestamp of the oldest page still in the buffer and of the newest page written, plus a flag that says the buffer has wrapped at least once. A mode input selects whether every antenna input is stored or only those with an even index. The two modes use different page strides in 512-bit memory words.

Top module: `page_ring_tracker`

## Requirements
- R1: After reset every output is zero. `recording` equals the value `recEnable` had at the previous rising clock edge.
- R2: A `pageDone` strobe is accepted only when `recEnable` is high and `recording` is already high. Any other strobe leaves every status output and `pageAddr` unchanged. This includes a strobe in the first enabled cycle and any strobe while recording is stopped.
- R3: The write index starts at 0 and advances by one per accepted page. After index `totalPages`-1 it returns to 0. `pageAddr` equals the write index times the page stride. `totalPages` must be at least 1 and held constant while recording.
- R4: In the cycle after `recEnable` rises while `recording` is low, the write index, both page indices, both timestamps and `filled` all read 0.
- R5: After an accepted page, `lastIdx` holds the write index that page used and `lastStamp` holds its `pageStamp`.
- R6: Until the buffer wraps, `firstIdx` stays 0 and `firstStamp` holds the stamp of the first page accepted after the restart. Once `filled` is set, each further page sets `firstIdx` to (`lastIdx`+1) modulo `totalPages` and raises `firstStamp` by 4672 samples.
- R7: `filled` is set when the page at index `totalPages`-1 is accepted. It stays set until recording restarts.
- R8: With `halfMode` low the page stride is 657 memory words. With `halfMode` high, when only even-indexed inputs are kept, the stride is 329.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| recEnable | input | 1 | Record enable shared by all antenna inputs |
| pageDone | input | 1 | One-cycle strobe: a page has been written |
| pageStamp | input | STAMP_W (64) | Sample-count timestamp of the completed page |
| halfMode | input | 1 | 1 = keep even-indexed inputs only (smaller page) |
| totalPages | input | PAGE_W (21) | Number of pages in the ring |
| pageAddr | output | ADDR_W (31) | Memory word address of the next page to write |
| recording | output | 1 | Recording active |
| filled | output | 1 | Ring has wrapped since the last restart |
| lastIdx | output | PAGE_W | Index of newest recorded page |
| lastStamp | output | STAMP_W | Timestamp of newest recorded page |
| firstIdx | output | PAGE_W | Index of oldest page still held |
| firstStamp | output | STAMP_W | Timestamp of oldest page still held |

## Verification
The bench sends long runs of pages with evenly spaced stamps into rings of five, three and one pages. The runs go two to three times around each ring. This separates behaviour before the first wrap, at the wrap page itself and during steady overwrite, and the one-page ring covers the case where the oldest and newest page coincide. Stray strobes are sent while recording is stopped and in the first enabled cycle, which shows whether the freeze and the start-up gating hold. Recording restarts in the other mode, which shows whether the status is cleared and whether the stride switches from 657 to 329 words.

// File: rtl/page_ring_pkg.sv
package page_ring_pkg;
  // Strobes from control to the datapath, one cycle each
  typedef struct packed {
    logic clear;      // recording (re)starts: zero all state
    logic advance;    // a page was accepted
    logic firstPage;  // accepted page is the first since the restart
    logic overwrite;  // accepted page replaces the oldest page
  } ringStrobes_t;
endpackage

// File: rtl/page_ring_ctrl.sv
module page_ring_ctrl
  import page_ring_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         recEnable,
  input  logic         pageDone,
  input  logic         atEnd,
  output logic         recording,
  output logic         filled,
  output ringStrobes_t strb
);
  logic gotPage;

  always_comb begin
    strb.clear     = recEnable & ~recording;
    strb.advance   = recEnable & recording & pageDone;
    strb.firstPage = strb.advance & ~gotPage;
    strb.overwrite = strb.advance & filled;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recording <= 1'b0;
      filled    <= 1'b0;
      gotPage   <= 1'b0;
    end else begin
      recording <= recEnable;
      if (strb.clear) begin
        filled  <= 1'b0;
        gotPage <= 1'b0;
      end else if (strb.advance) begin
        gotPage <= 1'b1;
        if (atEnd) filled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/page_ring_dp.sv
module page_ring_dp
  import page_ring_pkg::*;
#(
  parameter int PAGE_W     = 21,
  parameter int STAMP_W    = 64,
  parameter int WORDS_FULL = 657,
  parameter int WORDS_HALF = 329,
  parameter int SAMPLES    = 4672,
  parameter int ADDR_W     = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  ringStrobes_t       strb,
  input  logic [STAMP_W-1:0] pageStamp,
  input  logic               halfMode,
  input  logic [PAGE_W-1:0]  totalPages,
  output logic               atEnd,
  output logic [ADDR_W-1:0]  pageAddr,
  output logic [PAGE_W-1:0]  lastIdx,
  output logic [STAMP_W-1:0] lastStamp,
  output logic [PAGE_W-1:0]  firstIdx,
  output logic [STAMP_W-1:0] firstStamp
);
  localparam int STRIDE_W = $clog2(WORDS_FULL + 1);
  localparam logic [STRIDE_W-1:0] STRIDE_FULL = STRIDE_W'(WORDS_FULL);
  localparam logic [STRIDE_W-1:0] STRIDE_HALF = STRIDE_W'(WORDS_HALF);

  logic [PAGE_W-1:0]   writeIdx;
  logic [PAGE_W-1:0]   nextIdx;
  logic [STRIDE_W-1:0] stride;

  assign atEnd   = (writeIdx == totalPages - PAGE_W'(1));
  assign nextIdx = atEnd ? '0 : writeIdx + PAGE_W'(1);
  assign stride  = halfMode ? STRIDE_HALF : STRIDE_FULL;
  assign pageAddr = ADDR_W'(writeIdx) * ADDR_W'(stride);

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      writeIdx   <= '0;
      lastIdx    <= '0;
      lastStamp  <= '0;
      firstIdx   <= '0;
      firstStamp <= '0;
    end else if (strb.advance) begin
      writeIdx  <= nextIdx;
      lastIdx   <= writeIdx;
      lastStamp <= pageStamp;
      if (strb.firstPage) begin
        firstIdx   <= '0;
        firstStamp <= pageStamp;
      end else if (strb.overwrite) begin
        firstIdx   <= nextIdx;
        firstStamp <= firstStamp + STAMP_W'(SAMPLES);
      end
    end
  end
endmodule

// File: rtl/page_ring_tracker.sv
module page_ring_tracker
  import page_ring_pkg::*;
#(
  parameter int PAGE_W     = 21,
  parameter int STAMP_W    = 64,
  parameter int WORDS_FULL = 657,
  parameter int WORDS_HALF = 329,
  parameter int SAMPLES    = 4672,
  localparam int ADDR_W    = PAGE_W + $clog2(WORDS_FULL + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               recEnable,
  input  logic               pageDone,
  input  logic [STAMP_W-1:0] pageStamp,
  input  logic               halfMode,
  input  logic [PAGE_W-1:0]  totalPages,
  output logic [ADDR_W-1:0]  pageAddr,
  output logic               recording,
  output logic               filled,
  output logic [PAGE_W-1:0]  lastIdx,
  output logic [STAMP_W-1:0] lastStamp,
  output logic [PAGE_W-1:0]  firstIdx,
  output logic [STAMP_W-1:0] firstStamp
);
  ringStrobes_t strb;
  logic         atEnd;

  page_ring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .recEnable(recEnable), .pageDone(pageDone),
    .atEnd(atEnd), .recording(recording), .filled(filled), .strb(strb)
  );

  page_ring_dp #(
    .PAGE_W(PAGE_W), .STAMP_W(STAMP_W), .WORDS_FULL(WORDS_FULL),
    .WORDS_HALF(WORDS_HALF), .SAMPLES(SAMPLES), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pageStamp(pageStamp),
    .halfMode(halfMode), .totalPages(totalPages), .atEnd(atEnd),
    .pageAddr(pageAddr), .lastIdx(lastIdx), .lastStamp(lastStamp),
    .firstIdx(firstIdx), .firstStamp(firstStamp)
  );
endmodule

// File: rtl/page_ring_checker.sv
module page_ring_checker #(
  parameter int PAGE_W  = 21,
  parameter int STAMP_W = 64
) (
  input logic               clk,
  input logic               rstN,
  input logic               recEnable,
  input logic               recording,
  input logic               filled,
  input logic [PAGE_W-1:0]  totalPages,
  input logic [PAGE_W-1:0]  lastIdx,
  input logic [PAGE_W-1:0]  firstIdx,
  input logic [STAMP_W-1:0] lastStamp,
  input logic [STAMP_W-1:0] firstStamp
);
  AST_REC_ON: assert property (@(posedge clk) disable iff (!rstN)
    recEnable |=> recording); // R1
  AST_REC_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !recEnable |=> !recording); // R1
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !recEnable |=> ($stable(lastIdx) && $stable(lastStamp) && $stable(firstIdx)
                    && $stable(firstStamp) && $stable(filled))); // R2
  AST_LAST_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (recording && totalPages != '0) |-> (lastIdx < totalPages)); // R3
  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (recEnable && !recording) |=> (lastIdx == '0 && firstIdx == '0 && !filled
                                   && lastStamp == '0 && firstStamp == '0)); // R4
  AST_OLDEST_AFTER_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
    (filled && recording) |->
      (firstIdx == ((lastIdx == totalPages - PAGE_W'(1)) ? '0 : lastIdx + PAGE_W'(1)))); // R6
  AST_FILLED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (filled && recording && recEnable) |=> filled); // R7
endmodule

bind page_ring_tracker page_ring_checker #(.PAGE_W(PAGE_W), .STAMP_W(STAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .recEnable(recEnable), .recording(recording),
  .filled(filled), .totalPages(totalPages), .lastIdx(lastIdx),
  .firstIdx(firstIdx), .lastStamp(lastStamp), .firstStamp(firstStamp)
);

// File: tb/test_page_ring_tracker.sv
module test_page_ring_tracker;
  localparam int PAGE_W  = 21;
  localparam int STAMP_W = 64;
  localparam int ADDR_W  = 31;
  localparam longint SPP = 4672;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic recEnable = 1'b0;
  logic pageDone = 1'b0;
  logic [STAMP_W-1:0] pageStamp = '0;
  logic halfMode = 1'b0;
  logic [PAGE_W-1:0] totalPages = PAGE_W'(5);
  logic [ADDR_W-1:0] pageAddr;
  logic recording, filled;
  logic [PAGE_W-1:0] lastIdx, firstIdx;
  logic [STAMP_W-1:0] lastStamp, firstStamp;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // bench model
  longint mWr, mLast, mLastS, mFirst, mFirstS;
  bit mFilled, mGot, mRec;

  always #5 clk = ~clk;

  page_ring_tracker i_page_ring_tracker (
    .clk(clk), .rstN(rstN), .recEnable(recEnable), .pageDone(pageDone),
    .pageStamp(pageStamp), .halfMode(halfMode), .totalPages(totalPages),
    .pageAddr(pageAddr), .recording(recording), .filled(filled),
    .lastIdx(lastIdx), .lastStamp(lastStamp), .firstIdx(firstIdx),
    .firstStamp(firstStamp)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string ctx);
    longint stride = halfMode ? 329 : 657;
    chk({ctx, " R1 recording"}, longint'(recording), longint'(mRec));
    chk({ctx, halfMode ? " R8 pageAddr" : " R3 pageAddr"}, longint'(pageAddr), mWr * stride);
    chk({ctx, " R5 lastIdx"}, longint'(lastIdx), mLast);
    chk({ctx, " R5 lastStamp"}, longint'(lastStamp), mLastS);
    chk({ctx, " R6 firstIdx"}, longint'(firstIdx), mFirst);
    chk({ctx, " R6 firstStamp"}, longint'(firstStamp), mFirstS);
    chk({ctx, " R7 filled"}, longint'(filled), longint'(mFilled));
  endtask

  task automatic clearModel();
    mWr = 0; mLast = 0; mLastS = 0; mFirst = 0; mFirstS = 0;
    mFilled = 0; mGot = 0;
  endtask

  task automatic sendPage(input longint s, input bit accept);
    longint n = longint'(totalPages);
    @(negedge clk);
    pageStamp = STAMP_W'(s);
    pageDone = 1'b1;
    @(negedge clk);
    pageDone = 1'b0;
    if (accept) begin
      mLast = mWr; mLastS = s;
      if (!mGot) begin mFirst = 0; mFirstS = s; mGot = 1; end
      else if (mFilled) begin mFirst = (mWr + 1) % n; mFirstS = mFirstS + SPP; end
      if (mWr == n - 1) mFilled = 1;
      mWr = (mWr + 1) % n;
    end
  endtask

  task automatic startRec();
    @(negedge clk);
    recEnable = 1'b1;
    @(negedge clk);
    mRec = 1; clearModel();
    checkAll("R4 restart");
  endtask

  task automatic stopRec();
    @(negedge clk);
    recEnable = 1'b0;
    @(negedge clk);
    mRec = 0;
    checkAll("R1 stop");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    longint base;
    clearModel(); mRec = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset");

    // R2: strobes while stopped are ignored
    sendPage(1000, 0);
    checkAll("R2 idle strobe");

    // five-page ring, full mode, 13 pages (wraps twice)
    totalPages = PAGE_W'(5); halfMode = 1'b0;
    startRec();
    base = 64'd900000;
    for (int k = 0; k < 13; k++) begin
      sendPage(base + k * SPP, 1);
      checkAll("R3 ring5");
    end
    stopRec();
    // R2: frozen contents after stop
    sendPage(base + 20 * SPP, 0);
    checkAll("R2 frozen");

    // three-page ring, half mode (R8), 8 pages
    totalPages = PAGE_W'(3); halfMode = 1'b1;
    startRec();
    base = 64'd5;
    for (int k = 0; k < 8; k++) begin
      sendPage(base + k * SPP, 1);
      checkAll("R8 ring3 half");
    end
    stopRec();

    // one-page ring
    totalPages = PAGE_W'(1); halfMode = 1'b0;
    startRec();
    for (int k = 0; k < 3; k++) begin
      sendPage(77 + k * SPP, 1);
      checkAll("R7 ring1");
    end
    stopRec();

    // R2: strobe in the first enabled cycle is ignored
    totalPages = PAGE_W'(4);
    @(negedge clk);
    recEnable = 1'b1;
    pageStamp = STAMP_W'(123);
    pageDone = 1'b1;
    @(negedge clk);
    pageDone = 1'b0;
    mRec = 1; clearModel();
    checkAll("R2 start strobe");
    sendPage(4000, 1);
    checkAll("R5 after start");

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule